// File: doc/BRIEF.md
# Eight-Channel DAC Register Bank Controller

This block is the digital core of an eight-channel digital-to-analog converter. It accepts fully assembled 32-bit command frames together with a one-cycle valid strobe. For every channel it holds two register stages: a staging (input) register that commands may load freely, and an active register whose value is the code sent to the converter. It also keeps a sleep state for each channel, a shared bias-enable flag, and a wake-up timer for each channel. A serial front end delivers frames. The analog side reads the active codes, the per-channel power state and the ready flags.

A frame carries a command in bits [23:20], a channel address in bits [19:16] and a data word in bits [15:0]. Bits [31:24] are padding and are ignored. The command can stage data, commit staged data, do both in one frame, or put channels to sleep. Any commit to a sleeping channel wakes it. A woken channel holds its ready flag low for a programmable number of clock cycles. That count is longer when every channel was asleep beforehand, because the shared bias circuit must restart first.

Top module: `octdac_bank`

## Requirements
- R1: After reset, every active code is 0, every channel is powered, every ready flag is 1 and the bias flag is 1. The staging registers are also 0, which a later commit shows.
- R2: Command 4'b0000 loads the data word into the staging register of the addressed channel only. No active code changes.
- R3: Command 4'b0001 copies the addressed channel's staging register into its active register on the edge that accepts the frame.
- R4: Command 4'b0011 loads the data word into the addressed channel's staging register and makes the same word its active code on the same edge.
- R5: Command 4'b0010 loads the data word into the addressed channel's staging register and commits the staging registers of all channels, including the new word.
- R6: Command 4'b0100 puts the addressed channel to sleep and ignores the data word. Neither register stage of that channel changes.
- R7: Address 4'b1111 selects every channel. Addresses 8 to 14 select no channel.
- R8: Command codes 4'b0101 to 4'b1111 change no output and no state.
- R9: A commit to a sleeping channel powers it. Its ready flag goes low and rises again exactly DLY_SHORT cycles after the accepting edge, provided at least one channel was powered before that frame.
- R10: If all channels were asleep before the waking frame, the ready flag rises exactly DLY_LONG cycles after the accepting edge.
- R11: The bias flag is 0 exactly when every channel is asleep.
- R12: A sleeping channel always reports ready 0. A commit to a powered, ready channel leaves its ready flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid_i | input | 1 | Frame strobe, one cycle per frame |
| frame_i | input | FRAME_W (32) | Command frame |
| dac_code_o | output | NUM_CH*DATA_W (128) | Active codes, channel 0 in the low bits |
| powered_o | output | NUM_CH (8) | Per-channel power state |
| ready_o | output | NUM_CH (8) | Per-channel ready flag |
| bias_on_o | output | 1 | Shared bias enable |

## Verification
Two collisions receive the most attention. The first is a staging write and a commit that reach the same register in one frame, through commands 0011 and 0010. This case shows whether the active register takes the new word or the stale staged one. The second is a wake-up that starts while other channels are still counting down, or just after every channel went to sleep. That case shows whether the short or the long delay is chosen from the power state before the frame. The bench sweeps every command against every address with idle gaps. A cycle-by-cycle arithmetic model of the staging registers, active registers, power bits and delay counters judges every output on every cycle.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

   localparam int CMD_W = 4;

   typedef enum logic [CMD_W-1:0] {
      OP_STAGE         = 4'b0000,
      OP_COMMIT        = 4'b0001,
      OP_STAGE_ALL     = 4'b0010,
      OP_STAGE_COMMIT  = 4'b0011,
      OP_SLEEP         = 4'b0100
   } op_e;

endpackage

// File: rtl/octdac_decode.sv
module octdac_decode
   import octdac_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [NUM_CH-1:0]  wr_o,
   output logic [NUM_CH-1:0]  upd_o,
   output logic [NUM_CH-1:0]  pd_o,
   output logic [DATA_W-1:0]  data_o
);

   localparam int ADDR_LSB = DATA_W;
   localparam int CMD_LSB  = DATA_W + ADDR_W;
   localparam int PAY_W    = CMD_LSB + CMD_W;
   localparam logic [ADDR_W-1:0] ALL_ADDR = {ADDR_W{1'b1}};

   logic [CMD_W-1:0]  cmd;
   logic [ADDR_W-1:0] addr;
   logic [NUM_CH-1:0] sel;

   assign cmd    = frame_i[CMD_LSB +: CMD_W];
   assign addr   = frame_i[ADDR_LSB +: ADDR_W];
   assign data_o = frame_i[DATA_W-1:0];

   generate
      if (FRAME_W > PAY_W) begin : g_pad
         logic pad_unused;
         assign pad_unused = ^frame_i[FRAME_W-1:PAY_W];
      end
      for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
         assign sel[i] = (addr == ADDR_W'(i)) || (addr == ALL_ADDR);
      end
   endgenerate

   always_comb begin
      wr_o  = '0;
      upd_o = '0;
      pd_o  = '0;
      if (valid_i) begin
         case (cmd)
            OP_STAGE:        wr_o  = sel;
            OP_COMMIT:       upd_o = sel;
            OP_STAGE_ALL: begin
               wr_o  = sel;
               upd_o = '1;
            end
            OP_STAGE_COMMIT: begin
               wr_o  = sel;
               upd_o = sel;
            end
            OP_SLEEP:        pd_o  = sel;
            default: ;
         endcase
      end
   end

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i) |-> (wr_o == '0 && upd_o == '0 && pd_o == '0));

   p_all_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cmd == OP_STAGE_ALL) |-> (&upd_o));

endmodule

// File: rtl/octdac_wake_timer.sv
module octdac_wake_timer #(
   parameter int DLY_SHORT = 5,
   parameter int DLY_LONG  = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic start_i,
   input  logic long_i,
   output logic idle_o
);

   localparam int CNT_W = (DLY_LONG < 2) ? 1 : $clog2(DLY_LONG + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   generate
      if (DLY_LONG == DLY_SHORT) begin : g_one_delay
         logic long_unused;
         assign long_unused = long_i;
         assign load_val    = CNT_W'(DLY_SHORT);
      end else begin : g_two_delay
         assign load_val = long_i ? CNT_W'(DLY_LONG) : CNT_W'(DLY_SHORT);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear_i)        cnt_q <= '0;
      else if (start_i)        cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign idle_o = (cnt_q == '0);

   p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DLY_LONG));

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !clear_i) |=> !idle_o);

endmodule

// File: rtl/octdac_channel.sv
module octdac_channel #(
   parameter int DATA_W    = 16,
   parameter int DLY_SHORT = 5,
   parameter int DLY_LONG  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              upd_i,
   input  logic              pd_i,
   input  logic              all_down_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] code_o,
   output logic              powered_o,
   output logic              ready_o
);

   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] active_q;
   logic              pwr_q;
   logic              idle;
   logic              wake;

   assign wake = upd_i && !pwr_q && !pd_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q  <= '0;
         active_q <= '0;
         pwr_q    <= 1'b1;
      end else begin
         if (wr_i)  stage_q  <= data_i;
         if (upd_i) active_q <= wr_i ? data_i : stage_q;
         if (pd_i)       pwr_q <= 1'b0;
         else if (upd_i) pwr_q <= 1'b1;
      end
   end

   octdac_wake_timer #(
      .DLY_SHORT (DLY_SHORT),
      .DLY_LONG  (DLY_LONG)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (pd_i),
      .start_i (wake),
      .long_i  (all_down_i),
      .idle_o  (idle)
   );

   assign code_o    = active_q;
   assign powered_o = pwr_q;
   assign ready_o   = pwr_q && idle;

   p_sleep_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |=> (active_q == $past(active_q) && stage_q == $past(stage_q)));

   p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !upd_i) |=> (active_q == $past(active_q)));

   p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !wr_i) |=> (active_q == $past(stage_q)));

   p_wake_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> (powered_o && !ready_o));

   p_keep_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && upd_i && !pd_i) |=> ready_o);

endmodule

// File: rtl/octdac_bank.sv
module octdac_bank #(
   parameter int NUM_CH    = 8,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int FRAME_W   = 32,
   parameter int DLY_SHORT = 5,
   parameter int DLY_LONG  = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_valid_i,
   input  logic [FRAME_W-1:0]       frame_i,
   output logic [NUM_CH*DATA_W-1:0] dac_code_o,
   output logic [NUM_CH-1:0]        powered_o,
   output logic [NUM_CH-1:0]        ready_o,
   output logic                     bias_on_o
);

   localparam int PAY_W = DATA_W + ADDR_W + octdac_pkg::CMD_W;

   initial begin
      assert (FRAME_W >= PAY_W) else $error("frame too narrow for payload");
      assert (NUM_CH >= 1 && NUM_CH < (1 << ADDR_W))
         else $error("channel count must leave one address for broadcast");
      assert (DLY_SHORT >= 1) else $error("short delay must be at least 1");
      assert (DLY_LONG >= DLY_SHORT) else $error("long delay below short delay");
   end

   logic [NUM_CH-1:0] wr;
   logic [NUM_CH-1:0] upd;
   logic [NUM_CH-1:0] pd;
   logic [DATA_W-1:0] data;
   logic              all_down;

   octdac_decode #(
      .NUM_CH  (NUM_CH),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .FRAME_W (FRAME_W)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (frame_valid_i),
      .frame_i (frame_i),
      .wr_o    (wr),
      .upd_o   (upd),
      .pd_o    (pd),
      .data_o  (data)
   );

   assign all_down  = ~|powered_o;
   assign bias_on_o = ~all_down;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         octdac_channel #(
            .DATA_W    (DATA_W),
            .DLY_SHORT (DLY_SHORT),
            .DLY_LONG  (DLY_LONG)
         ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr[i]),
            .upd_i      (upd[i]),
            .pd_i       (pd[i]),
            .all_down_i (all_down),
            .data_i     (data),
            .code_o     (dac_code_o[i*DATA_W +: DATA_W]),
            .powered_o  (powered_o[i]),
            .ready_o    (ready_o[i])
         );
      end
   endgenerate

   p_bias_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bias_on_o) |-> (ready_o == '0));

   p_sleep_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bias_on_o) |-> (ready_o == '0 && powered_o == '0));

endmodule

// File: tb/octdac_bank_tb.sv
module octdac_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DW  = 16;
   localparam int DS  = 5;
   localparam int DL  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fv = 1'b0;
   logic [31:0]       frame = '0;
   logic [NCH*DW-1:0] codes;
   logic [NCH-1:0]    powered;
   logic [NCH-1:0]    ready;
   logic              bias;

   int vectors = 0;
   int errors  = 0;
   string tag = "R1";

   logic [DW-1:0] m_stage [NCH];
   logic [DW-1:0] m_act   [NCH];
   logic [NCH-1:0] m_pwr;
   int m_cnt [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   octdac_bank #(.DLY_SHORT(DS), .DLY_LONG(DL)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_valid_i (fv),
      .frame_i       (frame),
      .dac_code_o    (codes),
      .powered_o     (powered),
      .ready_o       (ready),
      .bias_on_o     (bias)
   );

   task automatic compare();
      logic [NCH-1:0] exp_rdy;
      for (int i = 0; i < NCH; i++) begin
         exp_rdy[i] = m_pwr[i] && (m_cnt[i] == 0);
         vectors++;
         if (codes[i*DW +: DW] !== m_act[i]) begin
            errors++;
            $display("FAIL %s ch%0d code: got %h expected %h", tag, i, codes[i*DW +: DW], m_act[i]);
         end
      end
      vectors++;
      if (powered !== m_pwr || ready !== exp_rdy || bias !== (|m_pwr)) begin
         errors++;
         $display("FAIL %s pwr/rdy/bias: got %b/%b/%b expected %b/%b/%b",
                  tag, powered, ready, bias, m_pwr, exp_rdy, |m_pwr);
      end
   endtask

   // Model of one clock edge, built from R2..R12
   task automatic model_edge(input logic v, input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
      logic all_down;
      logic wr, up, pd, sel;
      all_down = (m_pwr == '0);
      for (int i = 0; i < NCH; i++) begin
         sel = (a == 4'hF) || (a == 4'(i));
         wr = v && sel && (c == 4'd0 || c == 4'd2 || c == 4'd3);
         up = v && ((sel && (c == 4'd1 || c == 4'd3)) || c == 4'd2);
         pd = v && sel && (c == 4'd4);
         if (pd) begin
            m_pwr[i] = 1'b0;
            m_cnt[i] = 0;
         end else if (up && !m_pwr[i]) begin
            m_pwr[i] = 1'b1;
            m_cnt[i] = all_down ? DL : DS;
         end else if (m_cnt[i] != 0) begin
            m_cnt[i]--;
         end
         if (up) m_act[i] = wr ? d : m_stage[i];
         if (wr) m_stage[i] = d;
      end
   endtask

   task automatic cyc(input logic v, input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
      fv = v;
      frame = {8'hA5, c, a, d};
      @(posedge clk);
      model_edge(v, c, a, d);
      @(negedge clk);
      fv = 1'b0;
      compare();
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 4'h0, 4'h0, 16'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_stage[i] = '0;
         m_act[i] = '0;
         m_cnt[i] = 0;
      end
      m_pwr = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      compare();
      cyc(1'b1, 4'd1, 4'hF, 16'hFFFF);

      // Every command against every address
      for (int c = 0; c < 16; c++) begin
         for (int a = 0; a < 16; a++) begin
            case (c)
               0: tag = "R2";
               1: tag = "R3";
               2: tag = "R5";
               3: tag = "R4";
               4: tag = "R6";
               default: tag = "R8";
            endcase
            if (a >= NCH) tag = {tag, "/R7"};
            cyc(1'b1, 4'(c), 4'(a), 16'(c * 16'h1111 + a * 16'h0203 + 16'h05A3));
            idle(3);
         end
         tag = "R9";
         cyc(1'b1, 4'd1, 4'hF, 16'h0);
         idle(DL + 1);
      end

      // Long restart after every channel sleeps
      tag = "R11";
      for (int i = 0; i < NCH; i++) cyc(1'b1, 4'd4, 4'(i), 16'hDEAD);
      tag = "R10";
      cyc(1'b1, 4'd3, 4'd2, 16'h1234);
      idle(3);
      tag = "R9";
      cyc(1'b1, 4'd1, 4'd5, 16'h0);
      idle(DL + 2);
      tag = "R12";
      cyc(1'b1, 4'd3, 4'd2, 16'h4321);
      cyc(1'b1, 4'd4, 4'd6, 16'h0);
      idle(2);
      tag = "R10";
      cyc(1'b1, 4'd4, 4'hF, 16'h0);
      cyc(1'b1, 4'd2, 4'd0, 16'hBEEF);
      idle(DL + 2);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule